// File: doc/BRIEF.md
# Motion Sensor Interrupt Controller

This block gathers the event flags raised by the motion detection functions of a sensing chip (new sample, single and double tap, activity, inactivity, free fall, FIFO watermark and FIFO overrun). It latches them into one status byte and routes them onto two interrupt pins. Each source has an enable bit and a routing bit. The routing bit sends the source to pin A or to pin B. A pin is the OR of every enabled source routed to it, and a format bit inverts both pins together.

A flag clears in one of three ways, according to its kind. The new-sample flag clears when the data register is read and no fresh sample arrives in the same cycle. The tap, activity, inactivity, free-fall and overrun flags stay set until the status register is read. The watermark flag follows the FIFO fill level: it sets when the level equals the programmed threshold and drops by itself once the level falls below it. Software reaches the block through a flat register port with address, write strobe, write data, read strobe and combinational read data. A register read takes effect on its side effects at the clock edge that ends the read cycle.

Top module: `motion_irq_ctrl`

## Requirements
- R1: Register map on `reg_addr`: 0 enable, 1 routing, 2 format, 3 status (read-only, writes have no effect), 4 watermark threshold (8 bits), 5 data (reads return `sample_byte`). Every other address reads as zero. Written values read back from the next cycle.
- R2: A source whose routing bit is 0 drives `int_a`, and a source whose routing bit is 1 drives `int_b`. Each pin is the OR of (status AND enable) over the sources routed to it, so several sources can share one pin.
- R3: A source with its enable bit clear has no effect on either pin. Clearing the enable bit drops that source's contribution in the next cycle, while its status bit stays set.
- R4: With format bit 5 at 0 the pins are active high. With it at 1 both pins are inverted (active low), so an idle pin reads 1.
- R5: Status bit 7 (new sample) sets in the cycle after a `new_sample` pulse. It clears after a read of address 5, unless `new_sample` is high in that same cycle.
- R6: Status bits 6 (single tap), 5 (double tap), 4 (activity), 3 (inactivity), 2 (free fall) and 0 (overrun) set after a pulse on their input. They hold until a read of address 3, which clears them. An input pulse that arrives in the same cycle as the read wins, and its bit stays set.
- R7: Status bit 1 (watermark) sets when `fifo_level` (zero-extended to 8 bits) equals the threshold register, clears when it is below the threshold, and otherwise holds.
- R8: The enable and routing registers use the same bit order as the status register: 7 new sample, 6 single tap, 5 double tap, 4 activity, 3 inactivity, 2 free fall, 1 watermark, 0 overrun.
- R9: After reset every register and status bit is zero, so all sources are disabled, routed to `int_a`, and both pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe (side effects at the clock edge) |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| new_sample | input | 1 | Pulse: a new sample is available |
| tap_single | input | 1 | Pulse: single tap detected |
| tap_double | input | 1 | Pulse: double tap detected |
| act_evt | input | 1 | Pulse: activity detected |
| inact_evt | input | 1 | Pulse: inactivity detected |
| ff_evt | input | 1 | Pulse: free fall detected |
| ovr_evt | input | 1 | Pulse: FIFO overrun |
| fifo_level | input | LVL_W | Current FIFO sample count |
| sample_byte | input | 8 | Byte returned when address 5 is read |
| int_a | output | 1 | Interrupt pin A |
| int_b | output | 1 | Interrupt pin B |

## Verification
A wrong status bit shows at the ports in two places: on the next status read, and on the pin it is routed to, in the first cycle after the edge that corrupted it. Pin routing and polarity are combinational from the registers, so pins are compared against a model in every cycle. A routing, enable or polarity fault therefore appears within one cycle of the register write that exposes it. Clear-rule faults, such as the wrong kind of read clearing a flag, a lost simultaneous event, or a watermark that fails to release, appear at the pins as soon as the affected source is enabled.

// File: rtl/mic_pkg.sv
package mic_pkg;
  localparam int NSRC   = 8;
  localparam int B_DRDY = 7;
  localparam int B_STAP = 6;
  localparam int B_DTAP = 5;
  localparam int B_ACT  = 4;
  localparam int B_INACT = 3;
  localparam int B_FF   = 2;
  localparam int B_WM   = 1;
  localparam int B_OVR  = 0;

  // Flags cleared by a status read (all except new sample and watermark)
  localparam logic [NSRC-1:0] EVT_MASK = 8'b0111_1101;

  localparam int A_EN   = 0;
  localparam int A_MAP  = 1;
  localparam int A_FMT  = 2;
  localparam int A_STAT = 3;
  localparam int A_THR  = 4;
  localparam int A_DATA = 5;
  localparam int INV_BIT = 5;

  // Next watermark state from the current level and the threshold
  function automatic logic wm_next(logic cur, logic [7:0] lvl, logic [7:0] thr);
    if (lvl == thr)     return 1'b1;
    else if (lvl < thr) return 1'b0;
    else                return cur;
  endfunction

  // Level of one pin: OR of enabled, routed flags, then polarity
  function automatic logic pin_level(logic [NSRC-1:0] st, logic [NSRC-1:0] en,
                                     logic [NSRC-1:0] map, logic sel, logic inv);
    logic [NSRC-1:0] hit;
    hit = st & en & (sel ? map : ~map);
    return (|hit) ^ inv;
  endfunction
endpackage

// File: rtl/mic_regs.sv
module mic_regs
  import mic_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  input  logic [NSRC-1:0]   status_i,
  input  logic [7:0]        sample_i,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   map_q,
  output logic [7:0]        fmt_q,
  output logic [7:0]        thr_q,
  output logic [7:0]        rdata_o,
  output logic              stat_rd_o,
  output logic              data_rd_o
);
  logic sel_en, sel_map, sel_fmt, sel_stat, sel_thr, sel_data;

  assign sel_en   = (addr_i == ADDR_W'(A_EN));
  assign sel_map  = (addr_i == ADDR_W'(A_MAP));
  assign sel_fmt  = (addr_i == ADDR_W'(A_FMT));
  assign sel_stat = (addr_i == ADDR_W'(A_STAT));
  assign sel_thr  = (addr_i == ADDR_W'(A_THR));
  assign sel_data = (addr_i == ADDR_W'(A_DATA));

  assign stat_rd_o = rd_i && sel_stat;
  assign data_rd_o = rd_i && sel_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      map_q <= '0;
      fmt_q <= '0;
      thr_q <= '0;
    end else if (wr_i) begin
      if (sel_en)  en_q  <= wdata_i;
      if (sel_map) map_q <= wdata_i;
      if (sel_fmt) fmt_q <= wdata_i;
      if (sel_thr) thr_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_en)   rdata_o = en_q;
    if (sel_map)  rdata_o = map_q;
    if (sel_fmt)  rdata_o = fmt_q;
    if (sel_stat) rdata_o = status_i;
    if (sel_thr)  rdata_o = thr_q;
    if (sel_data) rdata_o = sample_i;
  end

  assert_en_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_en) |=> (en_q == $past(wdata_i)));
  assert_map_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i) |=> $stable(map_q));
endmodule

// File: rtl/mic_flags.sv
module mic_flags
  import mic_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  set_i,
  input  logic             stat_rd_i,
  input  logic             data_rd_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [7:0]       thr_i,
  output logic [NSRC-1:0]  status_q
);
  logic [7:0]      lvl8;
  logic [NSRC-1:0] clr_mask;
  logic [NSRC-1:0] status_d;

  assign lvl8 = 8'(level_i);

  always_comb begin
    clr_mask = '0;
    if (stat_rd_i) clr_mask = clr_mask | EVT_MASK;
    if (data_rd_i) clr_mask[B_DRDY] = 1'b1;
    status_d = (status_q & ~clr_mask) | (set_i & ~(NSRC'(1) << B_WM));
    status_d[B_WM] = wm_next(status_q[B_WM], lvl8, thr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assert_tap_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[B_STAP] |=> status_q[B_STAP]);
  assert_evt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[B_FF] && !stat_rd_i) |=> status_q[B_FF]);
  assert_drdy_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[B_DRDY] |=> status_q[B_DRDY]);
  assert_wm_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl8 == thr_i) |=> status_q[B_WM]);
  assert_wm_below_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl8 < thr_i) |=> !status_q[B_WM]);
endmodule

// File: rtl/mic_pins.sv
module mic_pins
  import mic_pkg::*;
#(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] status_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] map_i,
  input  logic            inv_i,
  output logic [NPIN-1:0] pins_o
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    assign pins_o[p] = pin_level(status_i, en_i, map_i, p[0], inv_i);
  end

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i & en_i) == '0) |-> (pins_o == {NPIN{inv_i}}));
  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |-> (pins_o == {NPIN{inv_i}}));
endmodule

// File: rtl/motion_irq_ctrl.sv
module motion_irq_ctrl
  import mic_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int LVL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  input  logic              new_sample,
  input  logic              tap_single,
  input  logic              tap_double,
  input  logic              act_evt,
  input  logic              inact_evt,
  input  logic              ff_evt,
  input  logic              ovr_evt,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [7:0]        sample_byte,
  output logic              int_a,
  output logic              int_b
);
  localparam int NPIN = 2;

  logic [NSRC-1:0] en_q, map_q, status_q, set_vec;
  logic [7:0]      fmt_q, thr_q;
  logic            stat_rd, data_rd;
  logic [NPIN-1:0] pins;

  always_comb begin
    set_vec          = '0;
    set_vec[B_DRDY]  = new_sample;
    set_vec[B_STAP]  = tap_single;
    set_vec[B_DTAP]  = tap_double;
    set_vec[B_ACT]   = act_evt;
    set_vec[B_INACT] = inact_evt;
    set_vec[B_FF]    = ff_evt;
    set_vec[B_OVR]   = ovr_evt;
  end

  mic_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr), .wr_i(reg_wr),
    .wdata_i(reg_wdata), .rd_i(reg_rd), .status_i(status_q),
    .sample_i(sample_byte), .en_q(en_q), .map_q(map_q), .fmt_q(fmt_q),
    .thr_q(thr_q), .rdata_o(reg_rdata), .stat_rd_o(stat_rd), .data_rd_o(data_rd)
  );

  mic_flags #(.LVL_W(LVL_W)) flags_i (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .stat_rd_i(stat_rd),
    .data_rd_i(data_rd), .level_i(fifo_level), .thr_i(thr_q),
    .status_q(status_q)
  );

  mic_pins #(.NPIN(NPIN)) pins_i (
    .clk(clk), .rst_n(rst_n), .status_i(status_q), .en_i(en_q),
    .map_i(map_q), .inv_i(fmt_q[INV_BIT]), .pins_o(pins)
  );

  assign int_a = pins[0];
  assign int_b = pins[1];

  assert_stat_rdclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tap_double) |=> !status_q[B_DTAP]);
endmodule

// File: tb/motion_irq_ctrl_tb_top.sv
module motion_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 3;
  localparam int LVL_W  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wd = '0, rdata, sbyte = 8'h00;
  logic [7:0] src = '0;  // bit positions match the status register
  logic [LVL_W-1:0] lvl = '0;
  logic int_a, int_b;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  logic [7:0] m_en = 0, m_map = 0, m_fmt = 0, m_thr = 0, m_st = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  motion_irq_ctrl #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wd),
    .reg_rd(rd), .reg_rdata(rdata), .new_sample(src[7]), .tap_single(src[6]),
    .tap_double(src[5]), .act_evt(src[4]), .inact_evt(src[3]), .ff_evt(src[2]),
    .ovr_evt(src[0]), .fifo_level(lvl), .sample_byte(sbyte),
    .int_a(int_a), .int_b(int_b)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    case (addr)
      3'd0: return m_en;
      3'd1: return m_map;
      3'd2: return m_fmt;
      3'd3: return m_st;
      3'd4: return m_thr;
      3'd5: return sbyte;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_pin(bit b);
    logic [7:0] hit;
    hit = m_st & m_en & (b ? m_map : ~m_map);
    return (hit != 0) ^ m_fmt[5];
  endfunction

  // One cycle: inputs already driven; check read, clock, update model, check pins
  task automatic tick(string req);
    logic [7:0] n;
    #1;
    if (rd) chk({req, " rdata R1"}, rdata, exp_rd());
    @(posedge clk);
    n = m_st;
    if (rd && addr == 3'd3) n = n & ~8'h7D;
    if (rd && addr == 3'd5) n[7] = 1'b0;
    n = n | (src & 8'hFD);
    if ({2'b00, lvl} == m_thr) n[1] = 1'b1;
    else if ({2'b00, lvl} < m_thr) n[1] = 1'b0;
    if (wr) begin
      if (addr == 3'd0) m_en = wd;
      if (addr == 3'd1) m_map = wd;
      if (addr == 3'd2) m_fmt = wd;
      if (addr == 3'd4) m_thr = wd;
    end
    m_st = n;
    @(negedge clk);
    chk({req, " int_a R2"}, int_a, exp_pin(1'b0));
    chk({req, " int_b R2"}, int_b, exp_pin(1'b1));
    wr = 0; rd = 0; src = 0;
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d, string req);
    addr = a; wd = d; wr = 1; tick(req);
  endtask

  task automatic rreg(logic [2:0] a, string req);
    addr = a; rd = 1; tick(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: reset state seen at the ports
    chk("R9 int_a", int_a, 0);
    chk("R9 int_b", int_b, 0);
    addr = 3'd0; #1; chk("R9 enable", rdata, 0);
    addr = 3'd1; #1; chk("R9 map", rdata, 0);
    addr = 3'd2; #1; chk("R9 fmt", rdata, 0);
    addr = 3'd4; #1; chk("R9 thr", rdata, 0);
    @(negedge clk);
    wreg(3'd4, 8'hFF, "R1 thr");        // park watermark below threshold
    rreg(3'd3, "R1 clear");
    // R1: readback, status read-only, unused address
    wreg(3'd0, 8'hA5, "R1 en");  rreg(3'd0, "R1 en rb");
    wreg(3'd3, 8'hFF, "R1 stat ro"); rreg(3'd3, "R1 stat ro rb");
    chk("R1 status ignores write", m_st, 0);
    sbyte = 8'h3C; rreg(3'd5, "R1 data"); rreg(3'd7, "R1 unused");
    // R2/R8: tap to pin B, free fall to pin A, sharing
    wreg(3'd0, 8'h00, "R3 off");
    wreg(3'd1, 8'h40, "R2 map");
    wreg(3'd0, 8'h44, "R8 en");
    src = 8'h40; tick("R2 tap");
    chk("R2 tap on int_b", int_b, 1); chk("R2 int_a idle", int_a, 0);
    src = 8'h04; tick("R2 ff");
    chk("R8 ff on int_a", int_a, 1);
    // R3: disable keeps status, drops pin
    wreg(3'd0, 8'h04, "R3 disable");
    chk("R3 int_b dropped", int_b, 0);
    rreg(3'd3, "R3 status kept");
    // R6: status read clears; simultaneous event wins
    wreg(3'd0, 8'hFF, "R6 en");
    src = 8'h20; addr = 3'd3; rd = 1; tick("R6 simultaneous");
    chk("R6 dtap survives", m_st[5], 1);
    chk("R6 int_a", int_a, 1);
    rreg(3'd3, "R6 clear");
    chk("R6 cleared int_a", int_a, 0);
    // R5: data-ready
    src = 8'h80; tick("R5 set");
    chk("R5 pin", int_a, 1);
    rreg(3'd3, "R5 status read keeps");
    chk("R5 kept after status read", int_a, 1);
    addr = 3'd5; rd = 1; src = 8'h80; tick("R5 read with new");
    chk("R5 still set", int_a, 1);
    rreg(3'd5, "R5 read clears");
    chk("R5 cleared", int_a, 0);
    // R7: watermark
    wreg(3'd1, 8'h02, "R7 map");
    wreg(3'd4, 8'd10, "R7 thr");
    lvl = 6'd9; tick("R7 below");   chk("R7 below", int_b, 0);
    lvl = 6'd10; tick("R7 equal");  chk("R7 equal", int_b, 1);
    lvl = 6'd12; tick("R7 above");  chk("R7 hold", int_b, 1);
    lvl = 6'd9; tick("R7 drop");    chk("R7 release", int_b, 0);
    // R4: polarity
    wreg(3'd2, 8'h20, "R4 invert");
    chk("R4 idle a", int_a, 1); chk("R4 idle b", int_b, 1);
    lvl = 6'd10; tick("R4 active"); chk("R4 active low", int_b, 0);
    // random phase
    void'($urandom(32'h1D2C3B4A));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      addr = r[2:0];
      wr = (r[5:3] == 0);
      rd = (r[7:6] != 0);
      wd = $urandom;
      src = ((r[10:8] == 0) ? 8'($urandom) : 8'h00);
      if (r[13:11] == 0) lvl = 6'($urandom % 20);
      sbyte = 8'($urandom);
      tick("R2 random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule